// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, for each incoming frame, whether the frame is kept or dropped. It sees the six destination address bytes one at a time, in wire order, on a byte stream. It sorts the frame into one of three classes: broadcast, multicast or unicast. It then applies the acceptance rule for that class. The result is a single-cycle decision pulse. The pulse carries an accept flag and a 2-bit code that gives the reason when the frame is rejected.

Software programs the filter through a 32-bit register write port. The registers are a control word, an entry-enable word and a single station address held in two words. The current register contents can be read back combinationally on the same select lines. A set of per-class accept bits governs broadcast and multicast frames. A unicast frame is either taken outright or compared with the stored station address. A complement control bit inverts the unicast comparison. The same bit also admits every broadcast and multicast frame.

The byte collector is a three-state machine. In IDLE it waits for a byte marked as start of frame and then moves to GATHER (transition *start*). In GATHER it counts bytes. A new start-of-frame byte restarts the count (transition *restart*). The sixth byte moves it to DECIDE (transition *complete*). DECIDE lasts one cycle, registers the decision and returns to IDLE (transition *done*).

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_reason` are 0, and every register reads back as 0.
- R2: Select 0 is the control word: bit 0 accepts all unicast, bit 1 accepts multicast, bit 2 accepts broadcast, bit 3 enables the address compare and bit 4 complements the result. It reads back in bits 4:0, and the bits above read 0. Select 2 holds address bytes 0..3, with byte 0 in bits 31:24 and byte 3 in bits 7:0. Select 3 holds byte 4 in bits 31:24 and byte 5 in bits 23:16. Its bits 15:0 read as 0.
- R3: Select 1 is the entry-enable word. Only bit 0 is stored. Writes to bits 15..1 are dropped, and all bits above bit 0 read as 0.
- R4: A frame whose 48 destination bits are all one is broadcast. It is accepted when control bit 4 or bit 2 is set. Otherwise it is rejected with reason 1.
- R5: A frame is multicast when bit 0 of the first destination byte is 1 and the frame is not broadcast. It is accepted when control bit 4 or bit 1 is set. Otherwise it is rejected with reason 2.
- R6: Any other frame is unicast. It is accepted without comparison when control bit 0 is set.
- R7: A unicast match needs three things: control bit 3 set, enable bit 0 set, and all six destination bytes equal to the stored address. With control bit 4 clear, a match is accepted and a non-match is rejected with reason 3.
- R8: With control bit 4 set, the unicast result is inverted. A match is rejected with reason 3 and a non-match is accepted.
- R9: The first destination byte is marked by `rx_sof`. Suppose the sixth byte is taken at clock edge N. Then `dec_valid` is high for exactly the one cycle that follows edge N+1, and an accepted frame carries reason 0.
- R10: A start-of-frame byte that arrives mid-address restarts collection with that byte as byte 0. Bytes without `rx_sof` that arrive while idle produce no decision.
- R11: Cycles with `rx_valid` low between address bytes pause collection without losing bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for write and readback |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational readback of the selected register |
| rx_valid | input | 1 | Byte valid on the receive stream |
| rx_sof | input | 1 | Marks the first destination byte of a frame |
| rx_byte | input | 8 | Receive stream byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted when high |
| dec_reason | output | 2 | 0 accepted, 1 broadcast rejected, 2 multicast rejected, 3 unicast rejected |

## Verification
Register readback is combinational, so it is sampled one time step after the select changes, away from any edge. The sixth address byte is driven half a cycle before edge N. The bench then checks three things at the falling edges that follow: no decision after edge N, the decision and its code after edge N+1, and a low `dec_valid` after edge N+2. This pins the pulse to one exact cycle. Gapped and restarted streams use the same count, taken from the edge that captures the final byte.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int MAC_BYTES = 6;
    localparam int MAC_W     = 8 * MAC_BYTES;

    typedef enum logic [1:0] {
        RSN_OK    = 2'd0,
        RSN_BCAST = 2'd1,
        RSN_MCAST = 2'd2,
        RSN_UCAST = 2'd3
    } reason_e;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_STA_HI = 2'd2,
        SEL_STA_LO = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_DECIDE = 2'd2
    } state_e;

    // bit 4 .. bit 0
    typedef struct packed {
        logic invert;
        logic cmp_en;
        logic acc_bc;
        logic acc_mc;
        logic acc_uc_all;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/daf_regs.sv
module daf_regs
    import daf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic              en0,
    output logic [MAC_W-1:0]  station,
    output logic [DATA_W-1:0] rdata
);
    localparam int LO_W = MAC_W - DATA_W;

    ctrl_t             ctrl_q;
    logic              en0_q;
    logic [DATA_W-1:0] sta_hi_q;
    logic [LO_W-1:0]   sta_lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            en0_q    <= 1'b0;
            sta_hi_q <= '0;
            sta_lo_q <= '0;
        end else if (we) begin
            unique case (reg_sel_e'(sel))
                SEL_CTRL:   ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
                SEL_ENABLE: en0_q    <= wdata[0];
                SEL_STA_HI: sta_hi_q <= wdata;
                SEL_STA_LO: sta_lo_q <= wdata[DATA_W-1 -: LO_W];
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_sel_e'(sel))
            SEL_CTRL:   rdata = DATA_W'(ctrl_q);
            SEL_ENABLE: rdata = DATA_W'(en0_q);
            SEL_STA_HI: rdata = sta_hi_q;
            SEL_STA_LO: rdata = {sta_lo_q, {(DATA_W-LO_W){1'b0}}};
            default:    rdata = '0;
        endcase
    end

    assign ctrl    = ctrl_q;
    assign en0     = en0_q;
    assign station = {sta_hi_q, sta_lo_q};
endmodule

// File: rtl/daf_collect.sv
module daf_collect
    import daf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic [7:0]       rx_byte,
    output logic [MAC_W-1:0] da,
    output logic             decide
);
    localparam int            CNT_W = $clog2(MAC_BYTES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAC_BYTES - 1);

    state_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [MAC_W-1:0] da_q;
    logic             take_sof, take_next;

    assign take_sof  = rx_valid && rx_sof && (state_q != ST_DECIDE);
    assign take_next = rx_valid && !rx_sof && (state_q == ST_GATHER);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_sof) state_d = ST_GATHER;
            ST_GATHER: if (take_next && cnt_q == LAST) state_d = ST_DECIDE;
            ST_DECIDE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            da_q  <= '0;
        end else if (take_sof) begin
            cnt_q <= CNT_W'(1);
            da_q  <= {da_q[MAC_W-9:0], rx_byte};
        end else if (take_next) begin
            cnt_q <= cnt_q + CNT_W'(1);
            da_q  <= {da_q[MAC_W-9:0], rx_byte};
        end
    end

    assign da     = da_q;
    assign decide = (state_q == ST_DECIDE);
endmodule

// File: rtl/daf_decide.sv
module daf_decide
    import daf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             decide,
    input  logic [MAC_W-1:0] da,
    input  ctrl_t            ctrl,
    input  logic             en0,
    input  logic [MAC_W-1:0] station,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic [1:0]       dec_reason
);
    logic    is_bc, is_mc, hit, acc;
    reason_e rsn;

    always_comb begin
        is_bc = &da;
        is_mc = da[MAC_W-8] && !is_bc;
        hit   = ctrl.cmp_en && en0 && (da == station);
        if (is_bc) begin
            acc = ctrl.invert || ctrl.acc_bc;
            rsn = acc ? RSN_OK : RSN_BCAST;
        end else if (is_mc) begin
            acc = ctrl.invert || ctrl.acc_mc;
            rsn = acc ? RSN_OK : RSN_MCAST;
        end else begin
            acc = ctrl.acc_uc_all || (ctrl.invert ? !hit : hit);
            rsn = acc ? RSN_OK : RSN_UCAST;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_reason <= RSN_OK;
        end else begin
            dec_valid  <= decide;
            dec_accept <= decide && acc;
            dec_reason <= decide ? rsn : RSN_OK;
        end
    end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_byte,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [1:0]        dec_reason
);
    ctrl_t            ctrl;
    logic             en0;
    logic [MAC_W-1:0] station;
    logic [MAC_W-1:0] da;
    logic             decide;

    daf_regs #(.DATA_W(DATA_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .ctrl(ctrl), .en0(en0), .station(station),
        .rdata(cfg_rdata)
    );

    daf_collect i_collect (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .da(da), .decide(decide)
    );

    daf_decide i_decide (
        .clk(clk), .rst_n(rst_n), .decide(decide), .da(da), .ctrl(ctrl),
        .en0(en0), .station(station), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_reason(dec_reason)
    );
endmodule

// File: rtl/daf_checker.sv
module daf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_sel,
    input logic [31:0] cfg_rdata,
    input logic        rx_valid,
    input logic        dec_valid,
    input logic        dec_accept,
    input logic [1:0]  dec_reason
);
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    p_byte_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_valid, 2));

    p_accept_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_accept) |-> dec_reason == 2'd0);

    p_reject_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept) |-> dec_reason != 2'd0);

    p_enable_high_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 2'd1) |-> cfg_rdata[31:1] == '0);

    p_low_word_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 2'd3) |-> cfg_rdata[15:0] == '0);
endmodule

bind dst_addr_filter daf_checker i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata),
    .rx_valid(rx_valid), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_reason(dec_reason)
);

// File: tb/test_dst_addr_filter.sv
module test_dst_addr_filter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        rx_valid;
    logic        rx_sof;
    logic [7:0]  rx_byte;
    logic        dec_valid;
    logic        dec_accept;
    logic [1:0]  dec_reason;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MCAST = 48'h0100_5E00_0001;
    localparam logic [47:0] STA   = 48'h0211_2233_4455;
    localparam logic [47:0] OTHER = 48'h0211_2233_4456;

    always #(CLK_PERIOD/2) clk = ~clk;

    dst_addr_filter i_dst_addr_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_byte(rx_byte), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_reason(dec_reason)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data);
        cfg_sel = sel;
        #1;
        data = cfg_rdata;
    endtask

    // sends six bytes, returns decision checked for its timing (R9)
    task automatic frame(input logic [47:0] a, input int gap,
                         output logic acc, output logic [1:0] rsn);
        for (int i = 0; i < 6; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = a[47-8*i -: 8];
            @(negedge clk);
            rx_valid = 1'b0; rx_sof = 1'b0;
            if (i < 5) repeat (gap) @(negedge clk);
        end
        chk("R9 no decision after capture edge", {31'b0, dec_valid}, 32'd0);
        @(negedge clk);
        chk("R9 decision one edge later", {31'b0, dec_valid}, 32'd1);
        acc = dec_accept; rsn = dec_reason;
        @(negedge clk);
        chk("R9 pulse ends", {31'b0, dec_valid}, 32'd0);
    endtask

    task automatic expect_frame(input string req, input logic [47:0] a, input int gap,
                                input logic exp_acc, input logic [1:0] exp_rsn);
        logic acc; logic [1:0] rsn;
        frame(a, gap, acc, rsn);
        chk({req, " accept"}, {31'b0, acc}, {31'b0, exp_acc});
        chk({req, " reason"}, {30'b0, rsn}, {30'b0, exp_rsn});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 dec_valid", {31'b0, dec_valid}, 32'd0);
        chk("R1 dec_accept", {31'b0, dec_accept}, 32'd0);
        chk("R1 dec_reason", {30'b0, dec_reason}, 32'd0);
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            chk("R1 register zero", v, 32'd0);
        end
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R2 control readback", v, 32'h1F);
        wr(2'd0, 32'h0000_000A); rd(2'd0, v); chk("R2 control bits", v, 32'h0A);
        wr(2'd2, 32'h0211_2233); rd(2'd2, v); chk("R2 high word", v, 32'h0211_2233);
        wr(2'd3, 32'h4455_ABCD); rd(2'd3, v); chk("R2 low word", v, 32'h4455_0000);
        wr(2'd1, 32'h0000_FFFF); rd(2'd1, v); chk("R3 enable only bit0", v, 32'd1);
        wr(2'd1, 32'h0000_FFFE); rd(2'd1, v); chk("R3 upper enables dropped", v, 32'd0);
        wr(2'd0, 32'd0);
    endtask

    task automatic t_bcast();
        wr(2'd0, 32'h00); expect_frame("R4 bcast blocked", BCAST, 0, 1'b0, 2'd1);
        wr(2'd0, 32'h04); expect_frame("R4 bcast allowed", BCAST, 0, 1'b1, 2'd0);
        wr(2'd0, 32'h10); expect_frame("R4 bcast by complement", BCAST, 0, 1'b1, 2'd0);
        wr(2'd0, 32'h02); expect_frame("R4 bcast not via mcast bit", BCAST, 0, 1'b0, 2'd1);
    endtask

    task automatic t_mcast();
        wr(2'd0, 32'h00); expect_frame("R5 mcast blocked", MCAST, 0, 1'b0, 2'd2);
        wr(2'd0, 32'h02); expect_frame("R5 mcast allowed", MCAST, 0, 1'b1, 2'd0);
        wr(2'd0, 32'h10); expect_frame("R5 mcast by complement", MCAST, 0, 1'b1, 2'd0);
        wr(2'd0, 32'h04); expect_frame("R5 mcast not via bcast bit", MCAST, 0, 1'b0, 2'd2);
    endtask

    task automatic t_ucast();
        wr(2'd2, 32'h0211_2233); wr(2'd3, 32'h4455_0000); wr(2'd1, 32'd1);
        wr(2'd0, 32'h08); expect_frame("R7 station match", STA, 0, 1'b1, 2'd0);
        expect_frame("R7 last byte differs", OTHER, 0, 1'b0, 2'd3);
        wr(2'd1, 32'd0); expect_frame("R7 entry disabled", STA, 0, 1'b0, 2'd3);
        wr(2'd1, 32'd1); wr(2'd0, 32'h00);
        expect_frame("R7 compare disabled", STA, 0, 1'b0, 2'd3);
        wr(2'd0, 32'h01); expect_frame("R6 accept all unicast", OTHER, 0, 1'b1, 2'd0);
    endtask

    task automatic t_invert();
        wr(2'd0, 32'h18);
        expect_frame("R8 match inverted", STA, 0, 1'b0, 2'd3);
        expect_frame("R8 mismatch inverted", OTHER, 0, 1'b1, 2'd0);
    endtask

    task automatic t_restart();
        wr(2'd0, 32'h08);
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = 8'hFF;
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0;
        expect_frame("R10 restart mid-address", STA, 0, 1'b1, 2'd0);
        for (int i = 0; i < 8; i++) begin
            rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'(i);
            @(negedge clk);
            chk("R10 idle bytes ignored", {31'b0, dec_valid}, 32'd0);
        end
        rx_valid = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk("R10 idle bytes ignored", {31'b0, dec_valid}, 32'd0);
        end
    endtask

    task automatic t_gaps();
        wr(2'd0, 32'h08);
        expect_frame("R11 gapped match", STA, 3, 1'b1, 2'd0);
        expect_frame("R11 gapped mismatch", OTHER, 1, 1'b0, 2'd3);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_byte = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_bcast();
        t_mcast();
        t_ucast();
        t_invert();
        t_restart();
        t_gaps();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule